// File: doc/BRIEF.md
# SDRAM Bank State Tracker

This block follows the row state of the four banks of a synchronous DRAM. It watches the command pins on every rising clock edge: chip select, row strobe, column strobe, write enable, address bit 10 and the two bank-select bits. From them it keeps, for each bank, whether a row is open and whether the bank has finished its precharge recovery. A memory controller or a protocol monitor can use these flags to schedule commands or to catch sequencing errors.

An activation opens an idle bank once that bank's recovery has run out. A precharge closes the banks it targets and starts a per-bank down-counter. Address bit 10 picks the target: one bank, or all banks at once. The recovery length, tRP, is a parameter in clock cycles. A read or a write to a closed bank raises a one-cycle illegal-command flag. So does an activation of a bank that is already open or still recovering. Every output is registered and shows the result of the command sampled at the previous edge.

Top module: `bank_tracker`

## Requirements
- R1: While `rst` is high and after it falls, every bank is idle (`bank_open` = 0000), every bank is ready (`bank_ready` = 1111) and `illegal_cmd` is low.
- R2: ACTIVE is `cs_n`=0 with `ras_n`,`cas_n`,`we_n` = 0,1,1. ACTIVE to a bank that is idle and ready sets bit `ba` of `bank_open` after that edge and leaves `illegal_cmd` low.
- R3: PRECHARGE is `cs_n`=0 with `ras_n`,`cas_n`,`we_n` = 0,1,0. PRECHARGE with `a10`=1 clears every bit of `bank_open`, whatever the value on `ba`.
- R4: PRECHARGE with `a10`=0 clears only bit `ba` of `bank_open` and leaves the other banks' open and ready bits unchanged.
- R5: Every bank that a PRECHARGE targets has `bank_ready` low for the TRP_CYCLES-1 cycles after that edge. The bit is high again from TRP_CYCLES cycles after the edge, so an ACTIVE exactly TRP_CYCLES edges later is accepted. A bank that is open is always ready.
- R6: READ (`ras_n`,`cas_n`,`we_n` = 1,0,1) or WRITE (1,0,0) to a bank whose `bank_open` bit is 0 drives `illegal_cmd` high for the one cycle after that edge and changes no bank state.
- R7: ACTIVE to a bank that is open, or whose `bank_ready` bit is low, drives `illegal_cmd` high for one cycle and changes no bank state.
- R8: With `cs_n`=1, or with any encoding other than the four above (NOP is 1,1,1), no bank state changes and `illegal_cmd` is low in the next cycle.
- R9: READ or WRITE to an open bank is legal: `illegal_cmd` stays low and no bank state changes; `a10` has no effect on these commands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all commands are sampled on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low; high inhibits the command |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| a10 | input | 1 | Precharge scope: 1 for all banks, 0 for the bank on `ba` |
| ba | input | 2 | Bank select |
| bank_open | output | 4 | One bit per bank, 1 when a row is open |
| bank_ready | output | 4 | One bit per bank, 1 when precharge recovery is done |
| illegal_cmd | output | 1 | One-cycle pulse after an illegal command |

## Verification
The bench checks that ba is ignored on an all-bank precharge: a tracker that decoded ba anyway would leave other banks open. It targets a single-bank precharge with other banks open, to catch a design that closes or stalls the wrong neighbours. It probes activation one cycle before and exactly at the tRP boundary; an off-by-one counter would either accept the early command or refuse the legal one. It also sends reads and writes to idle banks and re-activates open banks, with chip select high and with other encodings mixed in, so a tracker that changes state on an illegal or inhibited command shows a wrong open vector.

// File: rtl/sdram_bank_pkg.sv
package sdram_bank_pkg;

    localparam int BANK_W    = 2;
    localparam int NUM_BANKS = 1 << BANK_W;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_ACT,
        OP_PRE,
        OP_RD,
        OP_WR
    } op_e;

    typedef struct packed {
        op_e                   op;
        logic                  all_banks;
        logic [NUM_BANKS-1:0]  target;
    } bank_cmd_t;

    function automatic op_e decode_op(
        input logic cs_n,
        input logic ras_n,
        input logic cas_n,
        input logic we_n
    );
        op_e res;
        res = OP_NONE;
        if (!cs_n) begin
            unique case ({ras_n, cas_n, we_n})
                3'b011:  res = OP_ACT;
                3'b010:  res = OP_PRE;
                3'b101:  res = OP_RD;
                3'b100:  res = OP_WR;
                default: res = OP_NONE;
            endcase
        end
        return res;
    endfunction

    function automatic logic [NUM_BANKS-1:0] bank_onehot(input logic [BANK_W-1:0] b);
        logic [NUM_BANKS-1:0] v;
        v = '0;
        v[b] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/bank_cmd_decoder.sv
module bank_cmd_decoder
    import sdram_bank_pkg::*;
(
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic              a10,
    input  logic [BANK_W-1:0] ba,
    output bank_cmd_t         cmd
);

    always_comb begin
        cmd.op        = decode_op(cs_n, ras_n, cas_n, we_n);
        cmd.all_banks = (cmd.op == OP_PRE) && a10;
        cmd.target    = cmd.all_banks ? {NUM_BANKS{1'b1}} : bank_onehot(ba);
    end

endmodule

// File: rtl/bank_slot.sv
module bank_slot #(
    parameter int TRP_CYCLES = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic act_go,
    input  logic pre_go,
    output logic is_open,
    output logic is_ready
);

    localparam int CNT_W = (TRP_CYCLES < 2) ? 1 : $clog2(TRP_CYCLES);
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(TRP_CYCLES - 1);

    logic [CNT_W-1:0] recov_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            is_open   <= 1'b0;
            recov_cnt <= '0;
        end else if (pre_go) begin
            is_open   <= 1'b0;
            recov_cnt <= LOAD_VAL;
        end else begin
            if (act_go) begin
                is_open <= 1'b1;
            end
            if (recov_cnt != '0) begin
                recov_cnt <= recov_cnt - 1'b1;
            end
        end
    end

    assign is_ready = (recov_cnt == '0);

endmodule

// File: rtl/bank_tracker.sv
module bank_tracker
    import sdram_bank_pkg::*;
#(
    parameter int TRP_CYCLES = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cs_n,
    input  logic                 ras_n,
    input  logic                 cas_n,
    input  logic                 we_n,
    input  logic                 a10,
    input  logic [BANK_W-1:0]    ba,
    output logic [NUM_BANKS-1:0] bank_open,
    output logic [NUM_BANKS-1:0] bank_ready,
    output logic                 illegal_cmd
);

    bank_cmd_t            cmd;
    logic [NUM_BANKS-1:0] act_go;
    logic [NUM_BANKS-1:0] pre_go;
    logic                 sel_open;
    logic                 sel_ready;
    logic                 illegal_next;

    bank_cmd_decoder u_dec (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .a10   (a10),
        .ba    (ba),
        .cmd   (cmd)
    );

    assign sel_open  = |(bank_open  & cmd.target);
    assign sel_ready = |(bank_ready & cmd.target);

    always_comb begin
        illegal_next = 1'b0;
        unique case (cmd.op)
            OP_ACT:       illegal_next = sel_open || !sel_ready;
            OP_RD, OP_WR: illegal_next = !sel_open;
            default:      illegal_next = 1'b0;
        endcase
    end

    assign pre_go = (cmd.op == OP_PRE) ? cmd.target : '0;
    assign act_go = (cmd.op == OP_ACT && !illegal_next) ? cmd.target : '0;

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        bank_slot #(.TRP_CYCLES(TRP_CYCLES)) u_slot (
            .clk      (clk),
            .rst      (rst),
            .act_go   (act_go[g]),
            .pre_go   (pre_go[g]),
            .is_open  (bank_open[g]),
            .is_ready (bank_ready[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            illegal_cmd <= 1'b0;
        end else begin
            illegal_cmd <= illegal_next;
        end
    end

endmodule

// File: rtl/bank_tracker_sva.sv
module bank_tracker_sva
    import sdram_bank_pkg::*;
#(
    parameter int TRP_CYCLES = 3
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 cs_n,
    input logic                 ras_n,
    input logic                 cas_n,
    input logic                 we_n,
    input logic                 a10,
    input logic [BANK_W-1:0]    ba,
    input logic [NUM_BANKS-1:0] bank_open,
    input logic [NUM_BANKS-1:0] bank_ready,
    input logic                 illegal_cmd
);

    logic is_act, is_pre, is_rw, is_quiet;
    assign is_act   = !cs_n && ({ras_n, cas_n, we_n} == 3'b011);
    assign is_pre   = !cs_n && ({ras_n, cas_n, we_n} == 3'b010);
    assign is_rw    = !cs_n && (({ras_n, cas_n, we_n} == 3'b101) || ({ras_n, cas_n, we_n} == 3'b100));
    assign is_quiet = !is_act && !is_pre && !is_rw;

    // R1: reset state
    p_reset_state_r1: assert property (@(posedge clk)
        $past(rst) |-> (bank_open == '0 && bank_ready == '1 && !illegal_cmd));

    // R2: legal activation opens the bank
    p_act_opens_r2: assert property (@(posedge clk) disable iff (rst)
        (is_act && !bank_open[ba] && bank_ready[ba]) |=> (bank_open[$past(ba)] && !illegal_cmd));

    // R3: all-bank precharge
    p_pre_all_r3: assert property (@(posedge clk) disable iff (rst)
        (is_pre && a10) |=> (bank_open == '0));

    // R4: single-bank precharge leaves neighbours alone
    p_pre_one_r4: assert property (@(posedge clk) disable iff (rst)
        (is_pre && !a10) |=> (!bank_open[$past(ba)] &&
            ((bank_open & ~bank_onehot($past(ba))) == ($past(bank_open) & ~bank_onehot($past(ba))))));

    // R5: an open bank has finished recovery
    p_open_ready_r5: assert property (@(posedge clk) disable iff (rst)
        (bank_open & ~bank_ready) == '0);

    // R6: read or write to an idle bank
    p_rw_idle_r6: assert property (@(posedge clk) disable iff (rst)
        (is_rw && !bank_open[ba]) |=> (illegal_cmd && $stable(bank_open)));

    // R7: activation of an open or recovering bank
    p_act_bad_r7: assert property (@(posedge clk) disable iff (rst)
        (is_act && (bank_open[ba] || !bank_ready[ba])) |=> (illegal_cmd && $stable(bank_open)));

    // R8: inhibited or other commands do nothing
    p_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        is_quiet |=> (!illegal_cmd && $stable(bank_open)));

    // R9: read or write to an open bank is legal
    p_rw_open_r9: assert property (@(posedge clk) disable iff (rst)
        (is_rw && bank_open[ba]) |=> (!illegal_cmd && $stable(bank_open)));

endmodule

bind bank_tracker bank_tracker_sva #(.TRP_CYCLES(TRP_CYCLES)) u_sva (
    .clk         (clk),
    .rst         (rst),
    .cs_n        (cs_n),
    .ras_n       (ras_n),
    .cas_n       (cas_n),
    .we_n        (we_n),
    .a10         (a10),
    .ba          (ba),
    .bank_open   (bank_open),
    .bank_ready  (bank_ready),
    .illegal_cmd (illegal_cmd)
);

// File: tb/bank_tracker_test.sv
module bank_tracker_test;

    localparam int TRP = 3;
    localparam int NB  = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, a10 = 1'b0;
    logic [1:0] ba = 2'd0;
    logic [3:0] bank_open, bank_ready;
    logic       illegal_cmd;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // model state
    bit m_open [NB];
    int m_cnt  [NB];
    bit m_ill;

    bank_tracker #(.TRP_CYCLES(TRP)) uut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .a10(a10), .ba(ba),
        .bank_open(bank_open), .bank_ready(bank_ready), .illegal_cmd(illegal_cmd)
    );

    always #5 clk = ~clk;

    initial begin
        #1500000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    function automatic logic [3:0] exp_open();
        logic [3:0] v;
        for (int i = 0; i < NB; i++) v[i] = m_open[i];
        return v;
    endfunction

    function automatic logic [3:0] exp_ready();
        logic [3:0] v;
        for (int i = 0; i < NB; i++) v[i] = (m_cnt[i] == 0);
        return v;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < NB; i++) begin
            m_open[i] = 0;
            m_cnt[i]  = 0;
        end
        m_ill = 0;
    endtask

    // reference behaviour from the requirements, evaluated on pre-edge state
    task automatic model_step(input bit c, input bit r, input bit ca, input bit w,
                              input bit a, input int b);
        bit act, pre, rw;
        bit ill;
        act = !c && {r, ca, w} == 3'b011;
        pre = !c && {r, ca, w} == 3'b010;
        rw  = !c && ({r, ca, w} == 3'b101 || {r, ca, w} == 3'b100);
        ill = 0;
        if (act) ill = m_open[b] || (m_cnt[b] != 0);
        if (rw)  ill = !m_open[b];
        for (int i = 0; i < NB; i++) begin
            if (pre && (a || i == b)) begin
                m_open[i] = 0;
                m_cnt[i]  = TRP - 1;
            end else begin
                if (act && !ill && i == b) m_open[i] = 1;
                if (m_cnt[i] > 0) m_cnt[i]--;
            end
        end
        m_ill = ill;
    endtask

    task automatic check(input string req, input string what, input logic [3:0] act_v,
                         input logic [3:0] exp_v);
        checks++;
        if (act_v !== exp_v) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act_v, exp_v);
        end
    endtask

    task automatic check_all(input string req);
        check(req, "bank_open",   bank_open,   exp_open());
        check(req, "bank_ready",  bank_ready,  exp_ready());
        check(req, "illegal_cmd", {3'b0, illegal_cmd}, {3'b0, m_ill});
    endtask

    // drive at negedge, model after posedge, sample mid-cycle
    task automatic issue(input bit c, input bit r, input bit ca, input bit w,
                         input bit a, input int b, input string req);
        @(negedge clk);
        cs_n = c; ras_n = r; cas_n = ca; we_n = w; a10 = a; ba = 2'(b);
        @(posedge clk);
        model_step(c, r, ca, w, a, b);
        #2;
        check_all(req);
    endtask

    task automatic act(input int b, input string req);  issue(0, 0, 1, 1, 0, b, req); endtask
    task automatic pre(input bit a, input int b, input string req); issue(0, 0, 1, 0, a, b, req); endtask
    task automatic rd(input int b, input string req);   issue(0, 1, 0, 1, 0, b, req); endtask
    task automatic wr(input bit a, input int b, input string req); issue(0, 1, 0, 0, a, b, req); endtask
    task automatic nop(input string req);               issue(0, 1, 1, 1, 0, 0, req); endtask

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(posedge clk);
        #2;
        check_all("R1");
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #2;
        check_all("R1");

        // R2: open banks 0 and 2
        act(0, "R2");
        act(2, "R2");
        // R9: read/write to open banks, a10 set on write
        rd(0, "R9");
        wr(1, 2, "R9");
        // R6: access to idle banks
        wr(0, 1, "R6");
        rd(3, "R6");
        // R7: re-activate open bank
        act(0, "R7");
        // R4: close bank 0 only; bank 2 untouched
        pre(0, 0, "R4");
        // R7: activate during recovery, then boundary
        act(0, "R7");      // edge +1
        act(0, "R5");      // edge +2, still recovering (TRP-1 = 2)
        act(0, "R5");      // edge +3 == TRP: accepted
        // R8: chip select high with ACTIVE encoding, then other encodings
        issue(1, 0, 1, 1, 0, 1, "R8");
        issue(0, 0, 0, 1, 0, 1, "R8");   // refresh-like
        issue(0, 0, 0, 0, 0, 1, "R8");   // mode-register-like
        issue(0, 1, 1, 0, 0, 1, "R8");   // burst-stop-like
        nop("R8");
        // R3: all-bank precharge with ba pointing at an idle bank
        pre(1, 3, "R3");
        act(1, "R7");
        nop("R5");
        act(1, "R5");
        rd(1, "R9");

        // constrained random mix
        for (int n = 0; n < 3000; n++) begin
            int k;
            int b;
            k = $urandom_range(0, 99);
            b = $urandom_range(0, 3);
            if (k < 30)      act(b, "R2");
            else if (k < 40) pre(0, b, "R4");
            else if (k < 45) pre(1, b, "R3");
            else if (k < 65) rd(b, "R6");
            else if (k < 80) wr(1'($urandom_range(0, 1)), b, "R9");
            else if (k < 90) nop("R8");
            else issue(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                       1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                       1'($urandom_range(0, 1)), b, "R7");
        end

        // R1: reset from a busy state
        act(3, "R2");
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        model_reset();
        #2;
        check_all("R1");
        @(negedge clk);
        rst = 1'b0;

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule